// File: doc/BRIEF.md
# Parity Error Capture Latch

This block watches the result of a memory read parity check and turns a failure into a sticky error flag. A memory cycle is described to it by four one-clock strobes in the system clock domain: the start and end of a first timing pulse (TP2) and the start and end of a second one (TP3). The parity-good signal is sampled twice, once at the start of TP2 by a "slow" capture register and once at the end of TP2 by a "fast" capture register. The current memory-direction input selects which of the two captures counts. The fast capture counts while memory data is being driven out, and the slow capture counts otherwise.

The selected capture is the candidate error. It raises an interrupt request at once, if interrupts are enabled, and the main error register loads it at the end of TP3. Once the error is set, it forces both capture registers to keep reloading a failure, so the flag stays set. A clear request presented at the start of TP3 empties both capture registers. The error register then loads the empty capture at the end of TP3 and drops. Initialize resets all three registers. A skip-condition output reports the absence of an error.

Top module: `parity_err_latch`

## Requirements
- R1: While `init` is high, all three registers reset at the clock edge: afterwards `err_flag`=0, `irq`=0 and `skip_ok`=1.
- R2: With `mem_out`=0, a low `par_ok` in the cycle of `tp2_lead` makes `err_flag` go to 1 after the next `tp3_trail` strobe.
- R3: With `mem_out`=1, a low `par_ok` in the cycle of `tp2_trail` makes `err_flag` go to 1 after the next `tp3_trail` strobe.
- R4: Only the selected capture counts. With `mem_out`=1, a failure seen only at `tp2_lead` leaves `err_flag` at 0. With `mem_out`=0, a failure seen only at `tp2_trail` leaves `err_flag` at 0.
- R5: `err_flag` changes only on a cycle with `tp3_trail` (or `init`). Cycles without a strobe have no effect, whatever `par_ok` does.
- R6: `irq` is 1 when `irq_en`=1 and either the selected capture or the error flag is set, starting from the clock after the capturing strobe. `irq` is always 0 while `irq_en`=0.
- R7: Once `err_flag` is 1, it stays 1 through later memory cycles that have good parity, as long as no clear is requested.
- R8: `clr_req` high with `tp3_lead` empties both capture registers. `clr_req` high with the following `tp3_trail` then drops `err_flag` to 0.
- R9: If `clr_req` is high in the cycle of a TP2 strobe, the parity failure seen in that cycle is discarded and the register sampling at that strobe loads 0.
- R10: `skip_ok` is always the inverse of `err_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| init | input | 1 | Synchronous initialize, active high |
| par_ok | input | 1 | Parity checker reports good parity |
| mem_out | input | 1 | Memory data is driven out (selects fast capture) |
| tp2_lead | input | 1 | One-clock strobe at the start of TP2 |
| tp2_trail | input | 1 | One-clock strobe at the end of TP2 |
| tp3_lead | input | 1 | One-clock strobe at the start of TP3 |
| tp3_trail | input | 1 | One-clock strobe at the end of TP3 |
| clr_req | input | 1 | Clear request for the error |
| irq_en | input | 1 | Interrupts enabled |
| err_flag | output | 1 | Sticky parity error flag |
| irq | output | 1 | Interrupt request |
| skip_ok | output | 1 | High when no parity error is held |

## Verification
The bench builds the block with its default `IRQ_EARLY`=1, so the interrupt comes from the capture term. This lets it observe the request in the cycles between the TP2 strobes and `tp3_trail`, before the error flag is set. Fast and slow failures are driven under both direction states, including mismatched ones where a failure falls on the strobe that does not count. Sticky holding, clearing, and a clear that coincides with a failing TP2 strobe are all exercised, and idle cycles with bad parity show that nothing moves off-strobe.

// File: rtl/parity_err_latch.sv
module parity_err_latch #(
  parameter bit IRQ_EARLY = 1'b1
) (
  input  logic clk,
  input  logic init,
  input  logic par_ok,
  input  logic mem_out,
  input  logic tp2_lead,
  input  logic tp2_trail,
  input  logic tp3_lead,
  input  logic tp3_trail,
  input  logic clr_req,
  input  logic irq_en,
  output logic err_flag,
  output logic irq,
  output logic skip_ok
);

  logic fast_q, slow_q, err_q;
  logic sample_d, cap, irq_src;

  assign sample_d = clr_req ? 1'b0 : (~par_ok | err_q);
  assign cap      = mem_out ? fast_q : slow_q;

  always_ff @(posedge clk) begin
    if (init) begin
      fast_q <= 1'b0;
      slow_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (tp3_lead && clr_req) slow_q <= 1'b0;
      else if (tp2_lead)       slow_q <= sample_d;
      if (tp3_lead && clr_req) fast_q <= 1'b0;
      else if (tp2_trail)      fast_q <= sample_d;
      if (tp3_trail)           err_q  <= cap;
    end
  end

  generate
    if (IRQ_EARLY) begin : g_irq_early
      assign irq_src = cap | err_q;
    end else begin : g_irq_late
      assign irq_src = err_q;
    end
  endgenerate

  assign irq      = irq_en & irq_src;
  assign err_flag = err_q;
  assign skip_ok  = ~err_q;

  assert_init_clears_R1: assert property (@(posedge clk)
    init |=> (!err_q && !fast_q && !slow_q));

  assert_slow_path_only_R4: assert property (@(posedge clk) disable iff (init)
    (tp3_trail && !mem_out && !slow_q) |=> !err_q);

  assert_err_only_at_tp3_R5: assert property (@(posedge clk) disable iff (init)
    !tp3_trail |=> $stable(err_q));

  assert_no_irq_when_off_R6: assert property (@(posedge clk) disable iff (init)
    !irq_en |-> !irq);

  assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (init)
    (err_q && tp2_lead && !clr_req && !tp3_lead) |=> slow_q);

  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (init)
    (tp3_lead && clr_req) |=> (!fast_q && !slow_q));

  assert_clear_beats_fail_R9: assert property (@(posedge clk) disable iff (init)
    (tp2_trail && clr_req && !tp3_lead) |=> !fast_q);

endmodule

// File: tb/tb_parity_err_latch.sv
`timescale 1ns/1ps
module tb_parity_err_latch;
  logic clk = 1'b0;
  logic init = 1'b1, par_ok = 1'b1, mem_out = 1'b0;
  logic tp2_lead = 0, tp2_trail = 0, tp3_lead = 0, tp3_trail = 0;
  logic clr_req = 0, irq_en = 1;
  logic err_flag, irq, skip_ok;

  int compared = 0, mismatched = 0, cycles = 0;
  bit done = 0;
  logic [1:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  parity_err_latch dut (
    .clk(clk), .init(init), .par_ok(par_ok), .mem_out(mem_out),
    .tp2_lead(tp2_lead), .tp2_trail(tp2_trail), .tp3_lead(tp3_lead),
    .tp3_trail(tp3_trail), .clr_req(clr_req), .irq_en(irq_en),
    .err_flag(err_flag), .irq(irq), .skip_ok(skip_ok));

  // strobe: 0 none, 1 tp2_lead, 2 tp2_trail, 3 tp3_lead, 4 tp3_trail
  task automatic cyc(input int strobe, input logic pok, input logic mout,
                     input logic clr, input logic ien, input logic rst,
                     input logic e_err, input logic e_irq, input string tag);
    @(negedge clk); #1;
    init = rst; par_ok = pok; mem_out = mout; clr_req = clr; irq_en = ien;
    tp2_lead = (strobe == 1); tp2_trail = (strobe == 2);
    tp3_lead = (strobe == 3); tp3_trail = (strobe == 4);
    @(posedge clk); #1;
    exp_q.push_back({e_err, e_irq});
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      compared++;
      if (err_flag !== e[1] || irq !== e[0] || skip_ok !== ~e[1]) begin
        mismatched++;
        $display("FAIL %s: err/irq/skip got %b%b%b expected %b%b%b",
                 t, err_flag, irq, skip_ok, e[1], e[0], ~e[1]);
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000 && !done) begin
        mismatched++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    end
  end

  initial begin
    // R1 reset state
    cyc(0, 1, 0, 0, 1, 1, 0, 0, "R1 init");
    cyc(0, 0, 0, 0, 1, 0, 0, 0, "R5 idle bad parity");
    // R2 slow-path failure, mem_out=0
    cyc(1, 0, 0, 0, 1, 0, 0, 1, "R6 early irq slow");
    cyc(2, 1, 0, 0, 1, 0, 0, 1, "R5 no err before tp3");
    cyc(3, 1, 0, 0, 1, 0, 0, 1, "R5 no err at tp3_lead");
    cyc(4, 1, 0, 0, 1, 0, 1, 1, "R2 slow set");
    // R7 sticky over good cycle, R6 irq disabled
    cyc(1, 1, 0, 0, 0, 0, 1, 0, "R6 irq masked");
    cyc(2, 1, 0, 0, 0, 0, 1, 0, "R7 hold");
    cyc(3, 1, 0, 0, 0, 0, 1, 0, "R7 hold");
    cyc(4, 1, 0, 0, 0, 0, 1, 0, "R7 sticky");
    cyc(0, 0, 0, 0, 1, 0, 1, 1, "R10 skip low with error");
    // R8 clear
    cyc(3, 1, 0, 1, 1, 0, 1, 1, "R8 err held at tp3_lead");
    cyc(4, 1, 0, 1, 1, 0, 0, 0, "R8 cleared");
    // R3 fast-path failure, mem_out=1
    cyc(1, 1, 1, 0, 1, 0, 0, 0, "R3 good at lead");
    cyc(2, 0, 1, 0, 1, 0, 0, 1, "R6 early irq fast");
    cyc(3, 1, 1, 0, 1, 0, 0, 1, "R5 fast waits tp3");
    cyc(4, 1, 1, 0, 1, 0, 1, 1, "R3 fast set");
    cyc(3, 1, 1, 1, 1, 0, 1, 1, "R8 clear lead");
    cyc(4, 1, 1, 1, 1, 0, 0, 0, "R8 clear fast");
    // R4 mismatched strobes
    cyc(1, 0, 1, 0, 1, 0, 0, 0, "R4 slow ignored");
    cyc(2, 1, 1, 0, 1, 0, 0, 0, "R4 fast good");
    cyc(3, 1, 1, 0, 1, 0, 0, 0, "R4");
    cyc(4, 1, 1, 0, 1, 0, 0, 0, "R4 no err mem_out=1");
    cyc(1, 1, 0, 0, 1, 0, 0, 0, "R4 slow good");
    cyc(2, 0, 0, 0, 1, 0, 0, 0, "R4 fast ignored");
    cyc(3, 1, 0, 0, 1, 0, 0, 0, "R4");
    cyc(4, 1, 0, 0, 1, 0, 0, 0, "R4 no err mem_out=0");
    // R9 clear coinciding with failing tp2 strobe
    cyc(1, 0, 0, 1, 1, 0, 0, 0, "R9 slow fail discarded");
    cyc(2, 1, 0, 0, 1, 0, 0, 0, "R9");
    cyc(3, 1, 0, 0, 1, 0, 0, 0, "R9");
    cyc(4, 1, 0, 0, 1, 0, 0, 0, "R9 no err");
    cyc(1, 1, 1, 0, 1, 0, 0, 0, "R9 lead good");
    cyc(2, 0, 1, 1, 1, 0, 0, 0, "R9 fast fail discarded");
    cyc(4, 1, 1, 0, 1, 0, 0, 0, "R9 no err fast");
    // R1 init while error held
    cyc(1, 0, 0, 0, 1, 0, 0, 1, "R2 set again");
    cyc(4, 1, 0, 0, 1, 0, 1, 1, "R2 set again");
    cyc(0, 1, 0, 0, 1, 1, 0, 0, "R1 init clears error");
    cyc(4, 1, 0, 0, 1, 0, 0, 0, "R1 captures emptied");
    cyc(0, 1, 0, 0, 1, 0, 0, 0, "R10 drain");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule